// File: doc/BRIEF.md
# Parallel Character Descrambler with NRZI Decoder

This block takes one 10-bit character per accepted transfer from a deserializer. It decodes all ten bits in a single clock. First it reverses a self-synchronizing scrambler built on the polynomial x^9 + x^4 + 1. It then turns the NRZI-coded result back into NRZ. Bit 0 of each character is the earliest bit in time. The nine-bit scrambler history and the one-bit NRZI memory pass from the last bits of one character to the first bits of the next, so the serial bit stream is rebuilt exactly across character boundaries.

A bypass input sends the raw input character to the output unchanged. This serves streams that are not scrambled and diagnostic use. Latency is the same one register stage in both modes, so switching mode never shifts character alignment.

Both sides of the block use a valid/ready handshake. A character is accepted on a clock edge where `valid_in` and `in_ready` are both high. An output character is consumed on an edge where `valid_out` and `out_ready` are both high. Back-pressure works like this: while an output character waits unconsumed, it and `valid_out` hold steady and `in_ready` stays low. In that case no input is taken and the decoder state does not move. `in_ready` is high whenever the output register is empty or is being consumed in the same cycle.

Top module: `sdesc_top`

## Requirements
- R1: During and after reset, `valid_out` is 0, `data_out` is 0 and `in_ready` is 1. Reset clears the scrambler history and the NRZI memory to zero, so decoding after reset treats all earlier stream bits as 0.
- R2: In normal mode, the descrambled bit is d[n] = s[n] xor s[n-4] xor s[n-9]. Here s is the serial input stream, ordered bit 0 first within each character and characters in order of acceptance.
- R3: In normal mode, output bit y[n] = d[n] xor d[n-1], placed in `data_out` at the same bit position that s[n] had in `data_in`.
- R4: Only accepted characters advance the history and the NRZI memory. Cycles with `valid_in` low, or with `in_ready` low, leave the decode state unchanged.
- R5: With `bypass` high at acceptance, the output character equals the input character bit for bit.
- R6: Characters accepted in bypass mode still advance the scrambler history and the NRZI memory. A return to normal mode therefore continues decoding the stream without a gap.
- R7: While `valid_out` is 1 and `out_ready` is 0, `valid_out` stays 1 and `data_out` stays unchanged on the next clock.
- R8: `in_ready` equals (not `valid_out`) or `out_ready`.
- R9: An accepted character appears on `data_out` with `valid_out` high one clock after acceptance, in both modes. With nothing accepted and the output consumed, `valid_out` falls to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 10 | Scrambled NRZI character, bit 0 earliest |
| valid_in | input | 1 | Input character present |
| in_ready | output | 1 | Block can take a character this cycle |
| bypass | input | 1 | 1: pass raw characters, 0: decode |
| data_out | output | 10 | Decoded (or raw) character |
| valid_out | output | 1 | Output character present |
| out_ready | input | 1 | Downstream consumes the output character |

## Verification
The bench builds its input by NRZI-encoding and then scrambling known NRZ characters with a bit-serial model, and expects those same NRZ characters back.

- Constant zero and constant one characters exercise the feedback taps in opposite ways.
- Alternating and walking-one patterns show whether a tap sits at the wrong distance or the bit order is reversed.
- Long random runs with gaps on `valid_in` and random `out_ready` separate correct state carry across characters from state that moves on stalled or idle cycles.
- A bypass stretch followed by a return to normal decoding shows whether history keeps tracking while raw characters pass.

// File: rtl/sdesc_pkg.sv
package sdesc_pkg;
  localparam int CHAR_W  = 10;
  localparam int SCR_LEN = 9;
  localparam int SCR_TAP = 4;
  typedef logic [CHAR_W-1:0] char_t;
endpackage

// File: rtl/sdesc_unscramble.sv
// Unrolled self-synchronizing descrambler: W bits per clock, history of
// HIST_LEN scrambled bits carried across characters. Bit 0 is earliest.
module sdesc_unscramble #(
  parameter int W        = 10,
  parameter int HIST_LEN = 9,
  parameter int TAP      = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] s_in,
  output logic [W-1:0] d_out
);
  localparam int EXT_W = W + HIST_LEN;

  // hist[HIST_LEN-1] is the most recent scrambled bit, hist[0] the oldest
  logic [HIST_LEN-1:0] hist;
  logic [EXT_W-1:0]    ext;

  assign ext = {s_in, hist};

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign d_out[i] = ext[HIST_LEN+i] ^ ext[HIST_LEN+i-TAP] ^ ext[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   hist <= '0;
    else if (adv) hist <= ext[EXT_W-1 -: HIST_LEN];
  end

  // R6
  hist_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> hist[HIST_LEN-1] == $past(s_in[W-1]));

  // R4
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(hist));
endmodule

// File: rtl/sdesc_nrzi.sv
// Unrolled NRZI-to-NRZ decoder with one bit of memory between characters.
module sdesc_nrzi #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] y_out
);
  logic         prev;
  logic [W:0]   ext;

  assign ext = {d_in, prev};

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y_out[i] = ext[i+1] ^ ext[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   prev <= 1'b0;
    else if (adv) prev <= d_in[W-1];
  end

  // R6
  prev_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> prev == $past(d_in[W-1]));

  // R4
  prev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(prev));
endmodule

// File: rtl/sdesc_top.sv
module sdesc_top
  import sdesc_pkg::*;
#(
  parameter int W        = CHAR_W,
  parameter int HIST_LEN = SCR_LEN,
  parameter int TAP      = SCR_TAP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data_in,
  input  logic         valid_in,
  output logic         in_ready,
  input  logic         bypass,
  output logic [W-1:0] data_out,
  output logic         valid_out,
  input  logic         out_ready
);
  logic         take;
  logic [W-1:0] descr;
  logic [W-1:0] nrz;

  assign in_ready = !valid_out || out_ready;
  assign take     = valid_in && in_ready;

  sdesc_unscramble #(.W(W), .HIST_LEN(HIST_LEN), .TAP(TAP)) u_unscr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (take),
    .s_in  (data_in),
    .d_out (descr)
  );

  sdesc_nrzi #(.W(W)) u_nrzi (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (take),
    .d_in  (descr),
    .y_out (nrz)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      data_out  <= '0;
    end else if (take) begin
      valid_out <= 1'b1;
      data_out  <= bypass ? data_in : nrz;
    end else if (out_ready) begin
      valid_out <= 1'b0;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out && !out_ready |=> valid_out && $stable(data_out));

  // R5
  bypass_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in && in_ready && bypass |=> data_out == $past(data_in));

  // R9
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in && in_ready |=> valid_out);

  // R9
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in && out_ready |=> !valid_out);
endmodule

// File: tb/test_sdesc_top.sv
module test_sdesc_top;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] data_in = '0;
  logic         valid_in = 1'b0;
  logic         in_ready;
  logic         bypass = 1'b0;
  logic [W-1:0] data_out;
  logic         valid_out;
  logic         out_ready = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bit-serial reference state: sh[0] newest scrambled bit
  logic [8:0] sh = '0;
  logic       dlast = 1'b0;
  logic [W-1:0] expq[$];

  always #10 clk = ~clk;

  sdesc_top i_sdesc_top (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .valid_in(valid_in),
    .in_ready(in_ready), .bypass(bypass), .data_out(data_out),
    .valid_out(valid_out), .out_ready(out_ready)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // encode NRZ char to scrambled NRZI char, advancing the model
  function automatic logic [W-1:0] encode(input logic [W-1:0] y);
    logic [W-1:0] s;
    for (int n = 0; n < W; n++) begin
      logic d;
      d = y[n] ^ dlast;
      s[n] = d ^ sh[3] ^ sh[8];
      sh = {sh[7:0], s[n]};
      dlast = d;
    end
    return s;
  endfunction

  // advance the model with a raw char (bypass), decoding it serially
  function automatic void absorb(input logic [W-1:0] s);
    for (int n = 0; n < W; n++) begin
      logic d;
      d = s[n] ^ sh[3] ^ sh[8];
      sh = {sh[7:0], s[n]};
      dlast = d;
    end
  endfunction

  // one cycle: pattern sel picks the NRZ char; vprob/rprob in percent
  task automatic step(input logic [W-1:0] y, input bit byp, input int vprob, input int rprob, input string req);
    @(negedge clk);
    valid_in  = (($urandom % 100) < vprob);
    out_ready = (($urandom % 100) < rprob);
    bypass    = byp;
    data_in   = byp ? y : '0;
    #1;
    check("R8", {9'b0, in_ready}, {9'b0, (!valid_out || out_ready)});
    if (valid_out && out_ready) begin
      if (expq.size() == 0) check("R9", data_out, 'x);
      else check(req, data_out, expq.pop_front());
    end
    if (valid_in && in_ready) begin
      if (byp) begin
        absorb(y);
        expq.push_back(y);
      end else begin
        data_in = encode(y);
        expq.push_back(y);
      end
    end else if (!byp) begin
      data_in = W'($urandom);
    end
  endtask

  initial begin
    int guard = 0;
    while (!done && guard < 150000) begin
      @(posedge clk);
      guard++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", {9'b0, valid_out}, 10'd0);
    check("R1", data_out, 10'd0);
    check("R1", {9'b0, in_ready}, 10'd1);
    rst_n = 1'b1;

    // R2 R3: constant patterns, full throughput
    for (int k = 0; k < 20; k++) step('0, 0, 100, 100, "R2");
    for (int k = 0; k < 20; k++) step('1, 0, 100, 100, "R2");
    for (int k = 0; k < 20; k++) step(k[0] ? 10'h2AA : 10'h155, 0, 100, 100, "R3");
    for (int k = 0; k < 30; k++) begin
      pv = 10'd1 << (k % W);
      step(pv, 0, 100, 100, "R3");
    end
    // R4 R7: random data with gaps and back-pressure
    for (int k = 0; k < 600; k++) step(W'($urandom), 0, 70, 60, "R4");
    // R7: long stall
    for (int k = 0; k < 40; k++) step(W'($urandom), 0, 90, 10, "R7");
    // R5: bypass stretch
    for (int k = 0; k < 60; k++) step(W'($urandom), 1, 80, 70, "R5");
    // R6: back to normal, history must have followed raw chars
    for (int k = 0; k < 200; k++) step(W'($urandom), 0, 80, 70, "R6");
    // R6 R9: per-character mode changes
    for (int k = 0; k < 400; k++) step(W'($urandom), $urandom % 2, 90, 90, "R9");

    // drain
    for (int k = 0; k < 10 && expq.size() > 0; k++) step('0, 0, 0, 100, "R9");
    @(negedge clk);
    check("R9", {9'b0, valid_out}, 10'd0);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R9 actual %0d pending expected 0", expq.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule